// File: doc/BRIEF.md
# VLAN Table Access Engine

This block holds a 4096-entry VLAN table in on-chip RAM and gives a host register interface indirect access to it. Each entry carries a member port mask, an untag port mask and a filtering ID. The host fills three staging words: the VLAN ID, the two port masks and the filtering ID. It then writes a command word to the table access control register. A write command stores the staged entry at the staged VLAN ID. A read command fetches the entry at the staged VLAN ID into three read-back words.

The switch datapath looks entries up through a second, independent read port. That port returns an entry one cycle after it is given a VLAN ID. A busy output marks the cycles in which the engine owns the RAM's access port. Commands that arrive during those cycles are dropped.

Top module: `vlan_tbl_engine`

## Requirements
- R1: After reset, busy is 0 and all three staging words and all three read-back words read as zero.
- R2: Staging words sit at 0x0185 (VLAN ID, bits 11:0 kept), 0x0186 (member mask in bits 7:0, untag mask in bits 15:8, all 16 bits kept) and 0x0187 (filtering ID, bits 2:0 kept). Each reads back what was written, with the unkept bits reading as zero.
- R3: Writing 0x0F01 to the control register at 0x0180 while idle stores the staged entry at the staged VLAN ID. Busy is high for exactly the one cycle that follows the accepting edge.
- R4: Writing 0x0E01 to 0x0180 while idle reads the entry at the staged VLAN ID. Busy is high for the two cycles that follow the accepting edge. The read-back words then hold the VLAN ID at 0x018C, the masks at 0x018D (member in 7:0, untag in 15:8) and the filtering ID at 0x018E.
- R5: Only ports 0 to 5 exist. Mask bits 7:6 and 15:14 of staging word 1 are accepted, but the table stores them as zero, and both read-back and lookup return them as zero.
- R6: Any other value written to 0x0180 is ignored: busy stays low, the table is unchanged and the read-back words are unchanged.
- R7: A command written while busy is high is dropped. This includes a command in the last busy cycle.
- R8: The read-back words change only when a read command completes. A write command leaves them as they were.
- R9: The VLAN ID and entry are captured when a command is accepted. Staging writes made while busy do not alter the access in flight.
- R10: The lookup port presents the member mask, untag mask and filtering ID of the entry addressed by the lookup VLAN ID one cycle after a rising edge. A stored entry is visible to a lookup sampled at the edge that follows the storing edge.
- R11: All 4096 VLAN IDs address distinct entries, including ID 0 and ID 4095.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr_en | input | 1 | Host register write strobe |
| host_wr_addr | input | 16 | Host write address |
| host_wr_data | input | 16 | Host write data |
| host_rd_addr | input | 16 | Host read address (combinational read) |
| host_rd_data | output | 16 | Host read data |
| busy | output | 1 | Engine is performing a table access |
| lk_vid | input | 12 | Datapath lookup VLAN ID |
| lk_member | output | 6 | Looked-up member mask |
| lk_untag | output | 6 | Looked-up untag mask |
| lk_fid | output | 3 | Looked-up filtering ID |

## Verification
A command is accepted on the rising edge where the control write is strobed. Busy is therefore due half a cycle later. It falls one edge later for a write and two edges later for a read. Read-back words are due after that second edge, and a lookup result is due after the edge that follows the lookup ID. The bench drives every input on the falling edge and samples one falling edge after each counted rising edge, so every check lands on the first cycle in which its result is defined. The bench also checks mid-access values: busy is still high and the read-back words are still old.

// File: rtl/vlan_tbl_pkg.sv
// Shared constants for the VLAN table access engine.
// Assumes a 16-bit host register space; the addresses and command codes
// are decoded by host software and must not move.
package vlan_tbl_pkg;
    localparam int REG_W = 16;

    localparam logic [REG_W-1:0] ADDR_CTRL = 16'h0180;
    localparam logic [REG_W-1:0] ADDR_STG0 = 16'h0185;
    localparam logic [REG_W-1:0] ADDR_STG1 = 16'h0186;
    localparam logic [REG_W-1:0] ADDR_STG2 = 16'h0187;
    localparam logic [REG_W-1:0] ADDR_RB0  = 16'h018C;
    localparam logic [REG_W-1:0] ADDR_RB1  = 16'h018D;
    localparam logic [REG_W-1:0] ADDR_RB2  = 16'h018E;

    localparam logic [REG_W-1:0] CMD_WRITE = 16'h0F01;
    localparam logic [REG_W-1:0] CMD_READ  = 16'h0E01;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_WR      = 2'd1,
        ST_RD_ADDR = 2'd2,
        ST_RD_DATA = 2'd3
    } eng_state_t;
endpackage

// File: rtl/vlan_tbl_ram.sv
// Table storage: one write port, two registered read ports.
// Assumes the engine and the datapath may read in the same cycle; read
// data appears one cycle after the address. Contents are not reset.
module vlan_tbl_ram #(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] eng_addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] eng_rdata,
    input  logic [ADDR_W-1:0] lk_addr,
    output logic [DATA_W-1:0] lk_rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    // Store an entry when the engine commits a write.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[eng_addr] <= wdata;
        end
    end

    // Registered reads for the engine port and the lookup port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eng_rdata <= '0;
            lk_rdata  <= '0;
        end else begin
            eng_rdata <= mem[eng_addr];
            lk_rdata  <= mem[lk_addr];
        end
    end
endmodule

// File: rtl/vlan_tbl_regs.sv
// Host-visible register file: staging words, read-back words, read mux
// and control-register command decode.
// Assumes NUM_PORTS <= MASK_W; read-back masks are zero-extended.
module vlan_tbl_regs
    import vlan_tbl_pkg::*;
#(
    parameter int VID_W     = 12,
    parameter int NUM_PORTS = 6,
    parameter int FID_W     = 3,
    parameter int MASK_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [REG_W-1:0]     wr_addr,
    input  logic [REG_W-1:0]     wr_data,
    input  logic [REG_W-1:0]     rd_addr,
    output logic [REG_W-1:0]     rd_data,
    output logic [VID_W-1:0]     stg_vid,
    output logic [NUM_PORTS-1:0] stg_member,
    output logic [NUM_PORTS-1:0] stg_untag,
    output logic [FID_W-1:0]     stg_fid,
    output logic                 cmd_strobe,
    output logic [REG_W-1:0]     cmd_code,
    input  logic                 rb_load,
    input  logic [VID_W-1:0]     rb_vid,
    input  logic [NUM_PORTS-1:0] rb_member,
    input  logic [NUM_PORTS-1:0] rb_untag,
    input  logic [FID_W-1:0]     rb_fid
);
    logic [VID_W-1:0]     stg0_q;
    logic [REG_W-1:0]     stg1_q;
    logic [FID_W-1:0]     stg2_q;
    logic [VID_W-1:0]     rb_vid_q;
    logic [NUM_PORTS-1:0] rb_mem_q;
    logic [NUM_PORTS-1:0] rb_unt_q;
    logic [FID_W-1:0]     rb_fid_q;

    // Capture host writes into the staging words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg0_q <= '0;
            stg1_q <= '0;
            stg2_q <= '0;
        end else if (wr_en) begin
            if (wr_addr == ADDR_STG0) stg0_q <= wr_data[VID_W-1:0];
            if (wr_addr == ADDR_STG1) stg1_q <= wr_data;
            if (wr_addr == ADDR_STG2) stg2_q <= wr_data[FID_W-1:0];
        end
    end

    // Load read-back words only when the engine finishes a read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rb_vid_q <= '0;
            rb_mem_q <= '0;
            rb_unt_q <= '0;
            rb_fid_q <= '0;
        end else if (rb_load) begin
            rb_vid_q <= rb_vid;
            rb_mem_q <= rb_member;
            rb_unt_q <= rb_untag;
            rb_fid_q <= rb_fid;
        end
    end

    assign stg_vid    = stg0_q;
    assign stg_member = stg1_q[NUM_PORTS-1:0];
    assign stg_untag  = stg1_q[MASK_W +: NUM_PORTS];
    assign stg_fid    = stg2_q;
    assign cmd_strobe = wr_en && (wr_addr == ADDR_CTRL);
    assign cmd_code   = wr_data;

    // Host read mux; unmapped addresses return zero.
    always_comb begin
        rd_data = '0;
        case (rd_addr)
            ADDR_STG0: rd_data[VID_W-1:0] = stg0_q;
            ADDR_STG1: rd_data = stg1_q;
            ADDR_STG2: rd_data[FID_W-1:0] = stg2_q;
            ADDR_RB0:  rd_data[VID_W-1:0] = rb_vid_q;
            ADDR_RB1: begin
                rd_data[NUM_PORTS-1:0]      = rb_mem_q;
                rd_data[MASK_W +: NUM_PORTS] = rb_unt_q;
            end
            ADDR_RB2:  rd_data[FID_W-1:0] = rb_fid_q;
            default:   rd_data = '0;
        endcase
    end

    // R8: read-back words hold unless a read completes.
    a_r8_rb_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !rb_load |=> ($stable(rb_vid_q) && $stable(rb_mem_q)
                      && $stable(rb_unt_q) && $stable(rb_fid_q)));
endmodule

// File: rtl/vlan_tbl_ctrl.sv
// Command sequencer: accepts a command while idle, snapshots the staged
// VLAN ID and entry, then runs a one-cycle write or two-cycle read on
// the RAM's engine port. Assumes a registered RAM read.
module vlan_tbl_ctrl
    import vlan_tbl_pkg::*;
#(
    parameter int VID_W   = 12,
    parameter int ENTRY_W = 15
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_strobe,
    input  logic [REG_W-1:0]   cmd_code,
    input  logic [VID_W-1:0]   stg_vid,
    input  logic [ENTRY_W-1:0] stg_entry,
    output logic               busy,
    output logic               ram_we,
    output logic [VID_W-1:0]   ram_addr,
    output logic [ENTRY_W-1:0] ram_wdata,
    output logic               rb_load,
    output logic [VID_W-1:0]   rb_vid
);
    eng_state_t         state_q;
    logic [VID_W-1:0]   vid_q;
    logic [ENTRY_W-1:0] entry_q;

    // Sequence accesses and snapshot staged values on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            vid_q   <= '0;
            entry_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (cmd_strobe && cmd_code == CMD_WRITE) begin
                        state_q <= ST_WR;
                        vid_q   <= stg_vid;
                        entry_q <= stg_entry;
                    end else if (cmd_strobe && cmd_code == CMD_READ) begin
                        state_q <= ST_RD_ADDR;
                        vid_q   <= stg_vid;
                    end
                end
                ST_WR:      state_q <= ST_IDLE;
                ST_RD_ADDR: state_q <= ST_RD_DATA;
                ST_RD_DATA: state_q <= ST_IDLE;
                default:    state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy      = (state_q != ST_IDLE);
    assign ram_we    = (state_q == ST_WR);
    assign ram_addr  = vid_q;
    assign ram_wdata = entry_q;
    assign rb_load   = (state_q == ST_RD_DATA);
    assign rb_vid    = vid_q;

    // R3: a write keeps busy high for exactly one cycle.
    a_r3_wr_busy_one: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_strobe && cmd_code == CMD_WRITE) |=> busy ##1 !busy);

    // R4: a read keeps busy high for exactly two cycles.
    a_r4_rd_busy_two: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_strobe && cmd_code == CMD_READ) |=> busy ##1 busy ##1 !busy);

    // R6: unknown command codes start nothing.
    a_r6_bad_cmd_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && cmd_strobe && cmd_code != CMD_WRITE && cmd_code != CMD_READ)
        |=> !busy);

    // R7: a command in the final busy cycle does not restart the engine.
    a_r7_drop_last: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_WR || state_q == ST_RD_DATA) && cmd_strobe) |=> !busy);

    // R3: the RAM is written only in the cycle after a busy rise.
    a_r3_we_after_rise: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> $rose(busy));
endmodule

// File: rtl/vlan_tbl_engine.sv
// Top level: host register file, command sequencer and table RAM with a
// datapath lookup port. Assumes host software follows the staging /
// command protocol; entries are packed {fid, untag, member}.
module vlan_tbl_engine
    import vlan_tbl_pkg::*;
#(
    parameter int VID_W     = 12,
    parameter int NUM_PORTS = 6,
    parameter int FID_W     = 3,
    parameter int MASK_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 host_wr_en,
    input  logic [15:0]          host_wr_addr,
    input  logic [15:0]          host_wr_data,
    input  logic [15:0]          host_rd_addr,
    output logic [15:0]          host_rd_data,
    output logic                 busy,
    input  logic [VID_W-1:0]     lk_vid,
    output logic [NUM_PORTS-1:0] lk_member,
    output logic [NUM_PORTS-1:0] lk_untag,
    output logic [FID_W-1:0]     lk_fid
);
    localparam int ENTRY_W = 2 * NUM_PORTS + FID_W;

    logic [VID_W-1:0]     stg_vid;
    logic [NUM_PORTS-1:0] stg_member;
    logic [NUM_PORTS-1:0] stg_untag;
    logic [FID_W-1:0]     stg_fid;
    logic                 cmd_strobe;
    logic [REG_W-1:0]     cmd_code;
    logic                 rb_load;
    logic [VID_W-1:0]     rb_vid;
    logic                 ram_we;
    logic [VID_W-1:0]     ram_addr;
    logic [ENTRY_W-1:0]   ram_wdata;
    logic [ENTRY_W-1:0]   eng_rdata;
    logic [ENTRY_W-1:0]   lk_rdata;

    vlan_tbl_regs #(
        .VID_W(VID_W), .NUM_PORTS(NUM_PORTS), .FID_W(FID_W), .MASK_W(MASK_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(host_wr_en), .wr_addr(host_wr_addr), .wr_data(host_wr_data),
        .rd_addr(host_rd_addr), .rd_data(host_rd_data),
        .stg_vid(stg_vid), .stg_member(stg_member), .stg_untag(stg_untag),
        .stg_fid(stg_fid),
        .cmd_strobe(cmd_strobe), .cmd_code(cmd_code),
        .rb_load(rb_load), .rb_vid(rb_vid),
        .rb_member(eng_rdata[NUM_PORTS-1:0]),
        .rb_untag(eng_rdata[NUM_PORTS +: NUM_PORTS]),
        .rb_fid(eng_rdata[2*NUM_PORTS +: FID_W])
    );

    vlan_tbl_ctrl #(
        .VID_W(VID_W), .ENTRY_W(ENTRY_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .cmd_strobe(cmd_strobe), .cmd_code(cmd_code),
        .stg_vid(stg_vid), .stg_entry({stg_fid, stg_untag, stg_member}),
        .busy(busy), .ram_we(ram_we), .ram_addr(ram_addr),
        .ram_wdata(ram_wdata), .rb_load(rb_load), .rb_vid(rb_vid)
    );

    vlan_tbl_ram #(
        .ADDR_W(VID_W), .DATA_W(ENTRY_W)
    ) u_ram (
        .clk(clk), .rst_n(rst_n),
        .we(ram_we), .eng_addr(ram_addr), .wdata(ram_wdata),
        .eng_rdata(eng_rdata),
        .lk_addr(lk_vid), .lk_rdata(lk_rdata)
    );

    assign lk_member = lk_rdata[NUM_PORTS-1:0];
    assign lk_untag  = lk_rdata[NUM_PORTS +: NUM_PORTS];
    assign lk_fid    = lk_rdata[2*NUM_PORTS +: FID_W];

    // R5: mask bits above the last port never appear in read-back word 1.
    a_r5_rb_high_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd_addr == ADDR_RB1) |->
        (host_rd_data[MASK_W-1:NUM_PORTS] == '0
         && host_rd_data[REG_W-1:MASK_W+NUM_PORTS] == '0));
endmodule

// File: tb/vlan_tbl_engine_bench.sv
// Directed bench for the VLAN table access engine.
module vlan_tbl_engine_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr_en = 1'b0;
    logic [15:0] host_wr_addr = '0;
    logic [15:0] host_wr_data = '0;
    logic [15:0] host_rd_addr = '0;
    logic [15:0] host_rd_data;
    logic        busy;
    logic [11:0] lk_vid = '0;
    logic [5:0]  lk_member;
    logic [5:0]  lk_untag;
    logic [2:0]  lk_fid;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    localparam logic [15:0] A_CTRL = 16'h0180;
    localparam logic [15:0] A_S0 = 16'h0185, A_S1 = 16'h0186, A_S2 = 16'h0187;
    localparam logic [15:0] A_R0 = 16'h018C, A_R1 = 16'h018D, A_R2 = 16'h018E;
    localparam logic [15:0] C_WR = 16'h0F01, C_RD = 16'h0E01;

    vlan_tbl_engine u_vlan_tbl_engine (
        .clk(clk), .rst_n(rst_n),
        .host_wr_en(host_wr_en), .host_wr_addr(host_wr_addr),
        .host_wr_data(host_wr_data), .host_rd_addr(host_rd_addr),
        .host_rd_data(host_rd_data), .busy(busy),
        .lk_vid(lk_vid), .lk_member(lk_member), .lk_untag(lk_untag),
        .lk_fid(lk_fid)
    );

    always #10 clk = ~clk;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Called at a falling edge; returns at the falling edge after acceptance.
    task automatic host_wr(input logic [15:0] a, input logic [15:0] d);
        host_wr_en   = 1'b1;
        host_wr_addr = a;
        host_wr_data = d;
        step();
        host_wr_en   = 1'b0;
    endtask

    task automatic host_rd(input logic [15:0] a, output logic [31:0] d);
        host_rd_addr = a;
        #1;
        d = 32'(host_rd_data);
    endtask

    task automatic lookup(input logic [11:0] v, output logic [31:0] e);
        lk_vid = v;
        step();
        e = 32'({lk_fid, lk_untag, lk_member});
    endtask

    function automatic logic [31:0] pack(input logic [15:0] w1, input logic [2:0] f);
        return 32'({f, w1[13:8], w1[5:0]});
    endfunction

    task automatic write_entry(input logic [11:0] v, input logic [15:0] w1,
                               input logic [2:0] f);
        host_wr(A_S0, 16'(v));
        host_wr(A_S1, w1);
        host_wr(A_S2, 16'(f));
        host_wr(A_CTRL, C_WR);
        step();
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1", "busy", 32'(busy), 0);
        host_rd(A_S0, d); chk("R1", "stg0", d, 0);
        host_rd(A_S1, d); chk("R1", "stg1", d, 0);
        host_rd(A_S2, d); chk("R1", "stg2", d, 0);
        host_rd(A_R0, d); chk("R1", "rb0", d, 0);
        host_rd(A_R1, d); chk("R1", "rb1", d, 0);
        host_rd(A_R2, d); chk("R1", "rb2", d, 0);
    endtask

    task automatic t_staging();
        logic [31:0] d;
        host_wr(A_S0, 16'hFABC); host_rd(A_S0, d); chk("R2", "stg0 keeps 11:0", d, 32'h0ABC);
        host_wr(A_S1, 16'hA5C3); host_rd(A_S1, d); chk("R2", "stg1 full", d, 32'hA5C3);
        host_wr(A_S2, 16'hFFFD); host_rd(A_S2, d); chk("R2", "stg2 keeps 2:0", d, 32'h5);
    endtask

    task automatic t_write();
        logic [31:0] e;
        host_wr(A_S0, 16'h0123);
        host_wr(A_S1, 16'h2A15);
        host_wr(A_S2, 16'h0005);
        host_wr(A_CTRL, C_WR);
        chk("R3", "busy after accept", 32'(busy), 1);
        step();
        chk("R3", "busy one cycle", 32'(busy), 0);
        lookup(12'h123, e);
        chk("R10", "lookup after write", e, pack(16'h2A15, 3'd5));
    endtask

    task automatic t_read();
        logic [31:0] d;
        host_wr(A_S0, 16'h0123);
        host_wr(A_CTRL, C_RD);
        chk("R4", "busy cycle 1", 32'(busy), 1);
        step();
        chk("R4", "busy cycle 2", 32'(busy), 1);
        host_rd(A_R1, d); chk("R8", "rb1 not yet loaded", d, 0);
        step();
        chk("R4", "busy falls", 32'(busy), 0);
        host_rd(A_R0, d); chk("R4", "rb0 vid", d, 32'h0123);
        host_rd(A_R1, d); chk("R4", "rb1 masks", d, 32'h2A15);
        host_rd(A_R2, d); chk("R4", "rb2 fid", d, 32'h5);
    endtask

    task automatic t_trunc();
        logic [31:0] d;
        logic [31:0] e;
        write_entry(12'h200, 16'hFFFF, 3'd7);
        host_wr(A_CTRL, C_RD);
        step(); step();
        host_rd(A_R1, d); chk("R5", "rb1 high bits zero", d, 32'h3F3F);
        lookup(12'h200, e); chk("R5", "lookup masks 6 bits", e, 32'h7FFF);
    endtask

    task automatic t_bad_cmd();
        logic [31:0] d;
        logic [31:0] e;
        host_wr(A_S0, 16'h0123);
        host_wr(A_S1, 16'h0000);
        host_wr(A_S2, 16'h0000);
        host_wr(A_CTRL, 16'h0F02);
        chk("R6", "busy after 0x0F02", 32'(busy), 0);
        host_wr(A_CTRL, 16'h0E00);
        chk("R6", "busy after 0x0E00", 32'(busy), 0);
        step();
        host_rd(A_R0, d); chk("R6", "rb0 unchanged", d, 32'h0200);
        host_rd(A_R1, d); chk("R6", "rb1 unchanged", d, 32'h3F3F);
        lookup(12'h123, e); chk("R6", "table unchanged", e, pack(16'h2A15, 3'd5));
    endtask

    task automatic t_rb_hold();
        logic [31:0] d;
        write_entry(12'h300, 16'h0102, 3'd2);
        host_rd(A_R0, d); chk("R8", "rb0 held after write", d, 32'h0200);
        host_rd(A_R2, d); chk("R8", "rb2 held after write", d, 32'h7);
    endtask

    task automatic t_drop();
        logic [31:0] d;
        logic [31:0] e;
        write_entry(12'h00A, 16'h0102, 3'd1);
        host_wr(A_S1, 16'h0304);
        host_wr(A_S2, 16'h0002);
        host_wr(A_CTRL, C_RD);
        chk("R7", "busy read 1", 32'(busy), 1);
        host_wr(A_CTRL, C_WR);
        chk("R7", "busy read 2", 32'(busy), 1);
        host_wr(A_CTRL, C_WR);
        chk("R7", "late command dropped", 32'(busy), 0);
        host_rd(A_R1, d); chk("R7", "read result intact", d, 32'h0102);
        lookup(12'h00A, e); chk("R7", "dropped write left entry", e, pack(16'h0102, 3'd1));
    endtask

    task automatic t_snapshot();
        logic [31:0] e;
        host_wr(A_S0, 16'h0014);
        host_wr(A_S1, 16'h0A05);
        host_wr(A_S2, 16'h0003);
        host_wr(A_CTRL, C_WR);
        host_wr(A_S1, 16'h1F1F);
        lookup(12'h014, e); chk("R9", "snapshot entry stored", e, pack(16'h0A05, 3'd3));
    endtask

    task automatic t_edges();
        logic [31:0] e;
        write_entry(12'h000, 16'h0201, 3'd4);
        write_entry(12'hFFF, 16'h1020, 3'd6);
        lookup(12'h000, e); chk("R11", "vid 0", e, pack(16'h0201, 3'd4));
        lookup(12'hFFF, e); chk("R11", "vid 4095", e, pack(16'h1020, 3'd6));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_staging();
        t_write();
        t_read();
        t_trunc();
        t_bad_cmd();
        t_rb_hold();
        t_drop();
        t_snapshot();
        t_edges();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule